// File: doc/BRIEF.md
# UART Interrupt Combiner with Modem Loopback

This block keeps the raw interrupt causes of a serial port together with their enable mask, and drives six registered interrupt lines from the masked result: one combined line and one line each for receive, transmit, receive timeout, modem status and line errors. Software reaches it through a single-cycle write port that selects one of four registers: transmit data, control, mask and clear. Other logic of the port (receive level, timeout counter, error detectors) reports events through a one-cycle `hw_set` pulse vector.

The control register also carries the modem control outputs and a loopback enable. While loopback is on, every control write copies the modem outputs onto the modem status flags at once and rebuilds the four modem interrupt causes from them. Transmitted bytes and break requests are turned into receive items and offered to the receive buffer, and characters arriving from the external line are accepted and thrown away.

Receive items leave on a valid/ready stream (`rxq_*`). Outside loopback the external stream (`ext_*`) passes straight through with its back-pressure. In loopback a one-entry slot holds the looped item, keeping `rxq_valid` and `rxq_data` steady until `rxq_ready` is seen high at a clock edge. A loopback item produced while the slot is full and not being drained is lost, as a real receiver overrun would lose it.

Top module: `uart_irq_loop`

## Requirements
- R1: After reset the raw status, mask, modem flags, all six interrupt lines and `rxq_valid` are 0.
- R2: Cause bit positions are 0 ring indicator, 1 clear-to-send, 2 carrier detect, 3 data-set-ready, 4 receive, 5 transmit, 6 receive timeout, 7 framing, 8 parity, 9 break, 10 overrun. A 1 in `hw_set` sets that raw bit at the next edge.
- R3: Register select codes are 0 data, 1 control, 2 mask and 3 clear. A mask write replaces the mask with `wr_data[10:0]`. `irq_rx`, `irq_tx` and `irq_rto` follow masked bits 4, 5 and 6, `irq_mdm` follows any of masked bits 3:0, and `irq_err` follows any of masked bits 10:7. Each line shows the raw and mask values one cycle after they change.
- R4: `irq_all` is high exactly when any of the five other lines is high, and it has the same one-cycle delay.
- R5: A clear write drops every raw bit where `wr_data` holds a 1. A `hw_set` pulse on the same bit in the same cycle wins, and the bit stays set.
- R6: Every data write sets raw bit 5, whether loopback is on or off.
- R7: Control fields are bit 0 loopback enable, bit 1 DTR, bit 2 RTS, bit 3 Out1, bit 4 Out2 and bit 5 send break. A control write with bit 0 set, including the write that turns loopback on, sets the modem flags (same bit order as R2 bits 3:0) to ring=Out2, CTS=RTS, carrier=Out1 and DSR=DTR. A control write with bit 0 clear leaves the flags unchanged.
- R8: On such a loopback control write, raw bits 3:0 are replaced by the new flag values. This clears stale modem causes and overrides `hw_set` on those bits.
- R9: With loopback on, a data write offers the item {0, `wr_data[7:0]`}. A control write that keeps loopback on and raises the send-break bit from 0 offers the break item 0x100.
- R10: With loopback on, `ext_ready` is 1 and external items never reach `rxq`. With loopback off and the slot empty, `rxq_valid`/`rxq_data` equal `ext_valid`/`ext_data` and `ext_ready` equals `rxq_ready`.
- R11: A looped item stays on `rxq` unchanged until `rxq_ready` is high at an edge. A new looped item that arrives while the slot is full and `rxq_ready` is low is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 2 | Register select (R3) |
| wr_data | input | 16 | Write data |
| hw_set | input | 11 | Cause set pulses from the rest of the port |
| ext_valid | input | 1 | External receive item valid |
| ext_ready | output | 1 | External receive item accepted |
| ext_data | input | 9 | External item: bit 8 break, bits 7:0 character |
| rxq_valid | output | 1 | Item offered to the receive buffer |
| rxq_ready | input | 1 | Receive buffer accepts the item |
| rxq_data | output | 9 | Item: bit 8 break, bits 7:0 character |
| raw_status | output | 11 | Raw interrupt causes |
| int_mask | output | 11 | Interrupt enable mask |
| modem_flags | output | 4 | Modem status flags |
| irq_all | output | 1 | Combined interrupt |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rto | output | 1 | Receive timeout interrupt |
| irq_mdm | output | 1 | Modem status interrupt |
| irq_err | output | 1 | Line error interrupt |

## Verification
A corrupted raw or mask bit shows on `raw_status` or `int_mask` at the first falling edge after the write, and on the matching interrupt line exactly one cycle later. So the bench samples both points to catch a wrong value and also a wrong delay. A wrong loopback mapping shows directly on `modem_flags` and raw bits 3:0 after the enabling write, where a swapped pair of modem signals is visible. A slot that loses or overwrites its item shows on `rxq_data` while `rxq_ready` is held low, before the item could have been consumed.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NCAUSE = 11;
  localparam int NLINE  = 6;
  localparam int CTRL_W = 6;

  typedef enum logic [1:0] {
    SEL_DATA  = 2'd0,
    SEL_CTRL  = 2'd1,
    SEL_MASK  = 2'd2,
    SEL_CLEAR = 2'd3
  } reg_sel_e;

  // cause bit positions
  localparam int B_RI  = 0;
  localparam int B_CTS = 1;
  localparam int B_DCD = 2;
  localparam int B_DSR = 3;
  localparam int B_RX  = 4;
  localparam int B_TX  = 5;
  localparam int B_RTO = 6;

  // control field positions
  localparam int C_LBE  = 0;
  localparam int C_DTR  = 1;
  localparam int C_RTS  = 2;
  localparam int C_OUT1 = 3;
  localparam int C_OUT2 = 4;
  localparam int C_BRK  = 5;

  // line index: 0 combined, 1 rx, 2 tx, 3 timeout, 4 modem, 5 error
  function automatic logic [NCAUSE-1:0] line_group(input int line);
    logic [NCAUSE-1:0] g;
    g = '0;
    case (line)
      0: g = '1;
      1: g[B_RX] = 1'b1;
      2: g[B_TX] = 1'b1;
      3: g[B_RTO] = 1'b1;
      4: g[B_DSR:B_RI] = '1;
      default: g[NCAUSE-1:B_RTO+1] = '1;
    endcase
    return g;
  endfunction

  // modem status {DSR, DCD, CTS, RI} taken from the control outputs
  function automatic logic [3:0] modem_map(input logic [CTRL_W-1:0] c);
    logic [3:0] m;
    m[B_RI]  = c[C_OUT2];
    m[B_CTS] = c[C_RTS];
    m[B_DCD] = c[C_OUT1];
    m[B_DSR] = c[C_DTR];
    return m;
  endfunction
endpackage

// File: rtl/uart_irq_cause_regs.sv
module uart_irq_cause_regs
  import uart_irq_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [NCAUSE-1:0] hw_set,
  output logic [NCAUSE-1:0] raw_q,
  output logic [NCAUSE-1:0] mask_q,
  output logic [3:0]        flags_q,
  output logic              loop_on,
  output logic              push_tx,
  output logic              push_brk,
  output logic [DATA_W-1:0] tx_byte
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [NCAUSE-1:0] raw_d;
  logic [CTRL_W-1:0] ctrl_new;
  logic wr_data_sel, wr_ctrl_sel, wr_mask_sel, wr_clr_sel, lb_upd;

  assign ctrl_new    = wr_data[CTRL_W-1:0];
  assign wr_data_sel = wr_en && (wr_addr == SEL_DATA);
  assign wr_ctrl_sel = wr_en && (wr_addr == SEL_CTRL);
  assign wr_mask_sel = wr_en && (wr_addr == SEL_MASK);
  assign wr_clr_sel  = wr_en && (wr_addr == SEL_CLEAR);
  assign lb_upd      = wr_ctrl_sel && ctrl_new[C_LBE];

  assign loop_on  = ctrl_q[C_LBE];
  assign push_tx  = wr_data_sel && ctrl_q[C_LBE];
  assign push_brk = lb_upd && ctrl_new[C_BRK] && !ctrl_q[C_BRK];
  assign tx_byte  = wr_data[DATA_W-1:0];

  always_comb begin
    raw_d = raw_q;
    if (wr_clr_sel)  raw_d = raw_d & ~wr_data[NCAUSE-1:0];
    if (wr_data_sel) raw_d[B_TX] = 1'b1;
    raw_d = raw_d | hw_set;
    if (lb_upd)      raw_d[B_DSR:B_RI] = modem_map(ctrl_new);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q   <= '0;
      mask_q  <= '0;
      ctrl_q  <= '0;
      flags_q <= '0;
    end else begin
      raw_q <= raw_d;
      if (wr_mask_sel) mask_q <= wr_data[NCAUSE-1:0];
      if (wr_ctrl_sel) ctrl_q <= ctrl_new;
      if (lb_upd)      flags_q <= modem_map(ctrl_new);
    end
  end
endmodule

// File: rtl/uart_irq_lines.sv
module uart_irq_lines
  import uart_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCAUSE-1:0] raw_q,
  input  logic [NCAUSE-1:0] mask_q,
  output logic [NLINE-1:0]  irq_q
);
  logic [NCAUSE-1:0] masked;
  assign masked = raw_q & mask_q;

  for (genvar i = 0; i < NLINE; i++) begin : g_line
    localparam logic [NCAUSE-1:0] GRP = line_group(i);
    always_ff @(posedge clk) begin
      if (!rst_n) irq_q[i] <= 1'b0;
      else        irq_q[i] <= |(masked & GRP);
    end
  end
endmodule

// File: rtl/uart_irq_rx_path.sv
module uart_irq_rx_path #(
  parameter int DATA_W = 8,
  localparam int ITEM_W = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loop_on,
  input  logic              push_tx,
  input  logic              push_brk,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              ext_valid,
  output logic              ext_ready,
  input  logic [ITEM_W-1:0] ext_data,
  output logic              rxq_valid,
  input  logic              rxq_ready,
  output logic [ITEM_W-1:0] rxq_data
);
  logic              slot_full;
  logic [ITEM_W-1:0] slot_item;
  logic [ITEM_W-1:0] new_item;
  logic              push, room;

  assign push     = push_tx || push_brk;
  assign new_item = push_brk ? {1'b1, {DATA_W{1'b0}}} : {1'b0, tx_byte};
  assign room     = !slot_full || rxq_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_full <= 1'b0;
      slot_item <= '0;
    end else begin
      if (slot_full && rxq_ready) slot_full <= 1'b0;
      if (push && room) begin
        slot_full <= 1'b1;
        slot_item <= new_item;
      end
    end
  end

  assign rxq_valid = slot_full || (!loop_on && ext_valid);
  assign rxq_data  = slot_full ? slot_item : ext_data;
  assign ext_ready = loop_on ? 1'b1 : (rxq_ready && !slot_full);
endmodule

// File: rtl/uart_irq_loop.sv
module uart_irq_loop
  import uart_irq_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int DATA_W = 8,
  localparam int ITEM_W = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [NCAUSE-1:0] hw_set,
  input  logic              ext_valid,
  output logic              ext_ready,
  input  logic [ITEM_W-1:0] ext_data,
  output logic              rxq_valid,
  input  logic              rxq_ready,
  output logic [ITEM_W-1:0] rxq_data,
  output logic [NCAUSE-1:0] raw_status,
  output logic [NCAUSE-1:0] int_mask,
  output logic [3:0]        modem_flags,
  output logic              irq_all,
  output logic              irq_rx,
  output logic              irq_tx,
  output logic              irq_rto,
  output logic              irq_mdm,
  output logic              irq_err
);
  logic              loop_on, push_tx, push_brk;
  logic [DATA_W-1:0] tx_byte;
  logic [NLINE-1:0]  irq_q;

  uart_irq_cause_regs #(.REG_W(REG_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .hw_set(hw_set), .raw_q(raw_status),
    .mask_q(int_mask), .flags_q(modem_flags), .loop_on(loop_on),
    .push_tx(push_tx), .push_brk(push_brk), .tx_byte(tx_byte)
  );

  uart_irq_lines u_lines (
    .clk(clk), .rst_n(rst_n), .raw_q(raw_status), .mask_q(int_mask),
    .irq_q(irq_q)
  );

  uart_irq_rx_path #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .loop_on(loop_on), .push_tx(push_tx),
    .push_brk(push_brk), .tx_byte(tx_byte), .ext_valid(ext_valid),
    .ext_ready(ext_ready), .ext_data(ext_data), .rxq_valid(rxq_valid),
    .rxq_ready(rxq_ready), .rxq_data(rxq_data)
  );

  assign irq_all = irq_q[0];
  assign irq_rx  = irq_q[1];
  assign irq_tx  = irq_q[2];
  assign irq_rto = irq_q[3];
  assign irq_mdm = irq_q[4];
  assign irq_err = irq_q[5];
endmodule

// File: rtl/uart_irq_loop_chk.sv
module uart_irq_loop_chk
  import uart_irq_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int DATA_W = 8,
  localparam int ITEM_W = DATA_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [REG_W-1:0]  wr_data,
  input logic [NCAUSE-1:0] hw_set,
  input logic              ext_valid,
  input logic              ext_ready,
  input logic [ITEM_W-1:0] ext_data,
  input logic              rxq_valid,
  input logic              rxq_ready,
  input logic [ITEM_W-1:0] rxq_data,
  input logic [NCAUSE-1:0] raw_status,
  input logic [NCAUSE-1:0] int_mask,
  input logic [3:0]        modem_flags,
  input logic              irq_all,
  input logic              irq_rx,
  input logic              irq_tx,
  input logic              irq_rto,
  input logic              irq_mdm,
  input logic              irq_err
);
  logic lb_seen;
  always_ff @(posedge clk) begin
    if (!rst_n) lb_seen <= 1'b0;
    else if (wr_en && wr_addr == 2'd1) lb_seen <= wr_data[0];
  end

  AST_LINE_RX: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx == $past(raw_status[4] & int_mask[4])); // R3
  AST_LINE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err == $past(|(raw_status[10:7] & int_mask[10:7]))); // R3
  AST_COMBINED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_all == (irq_rx | irq_tx | irq_rto | irq_mdm | irq_err)); // R4
  AST_CLEAR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd3) |=>
      ((raw_status & $past(wr_data[NCAUSE-1:0]) & ~$past(hw_set)) == '0)); // R5
  AST_TX_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd0) |=> raw_status[5]); // R6
  AST_LOOP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd1 && wr_data[0]) |=>
      (modem_flags == {$past(wr_data[1]), $past(wr_data[3]),
                       $past(wr_data[2]), $past(wr_data[4])})); // R7
  AST_LOOP_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd1 && wr_data[0]) |=>
      (raw_status[3:0] == modem_flags)); // R8
  AST_EXT_SINK: assert property (@(posedge clk) disable iff (!rst_n)
    lb_seen |-> ext_ready); // R10
  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_seen && rxq_valid && !rxq_ready) |=>
      (rxq_valid && $stable(rxq_data))); // R11
endmodule

bind uart_irq_loop uart_irq_loop_chk #(.REG_W(REG_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_uart_irq_loop.sv
module tb_uart_irq_loop;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [10:0] hw_set = '0;
  logic        ext_valid = 1'b0;
  logic        ext_ready;
  logic [8:0]  ext_data = '0;
  logic        rxq_valid;
  logic        rxq_ready = 1'b0;
  logic [8:0]  rxq_data;
  logic [10:0] raw_status, int_mask;
  logic [3:0]  modem_flags;
  logic        irq_all, irq_rx, irq_tx, irq_rto, irq_mdm, irq_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_irq_loop dut (.*);

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_pulse(input logic [10:0] bits);
    @(negedge clk);
    hw_set = bits;
    @(negedge clk);
    hw_set = '0;
  endtask

  task automatic t_reset;
    check("R1", "raw", raw_status, 0);
    check("R1", "mask", int_mask, 0);
    check("R1", "flags", modem_flags, 0);
    check("R1", "irqs", {irq_all, irq_rx, irq_tx, irq_rto, irq_mdm, irq_err}, 0);
    check("R1", "rxq_valid", rxq_valid, 0);
  endtask

  task automatic t_route;
    reg_write(2'd2, 16'h07FF);
    set_pulse(11'h010);
    check("R2", "raw rx bit", raw_status, 11'h010);
    check("R3", "irq_rx before delay", irq_rx, 0);
    @(negedge clk);
    check("R3", "irq_rx after delay", irq_rx, 1);
    check("R4", "irq_all", irq_all, 1);
    check("R3", "irq_tx idle", irq_tx, 0);
    set_pulse(11'h100);
    @(negedge clk);
    check("R3", "irq_err parity", irq_err, 1);
    reg_write(2'd2, 16'h0000);
    check("R3", "irq_err held one cycle", irq_err, 1);
    @(negedge clk);
    check("R3", "irq_err masked", irq_err, 0);
    check("R4", "irq_all masked", irq_all, 0);
    reg_write(2'd3, 16'h07FF);
    check("R5", "raw cleared", raw_status, 0);
  endtask

  task automatic t_combined;
    reg_write(2'd2, 16'h0040);
    set_pulse(11'h041);
    @(negedge clk);
    check("R3", "irq_rto", irq_rto, 1);
    check("R3", "irq_mdm unmasked ring", irq_mdm, 0);
    check("R4", "irq_all from timeout", irq_all, 1);
    reg_write(2'd3, 16'h07FF);
    reg_write(2'd2, 16'h07FF);
  endtask

  task automatic t_clear;
    set_pulse(11'h130);
    check("R2", "raw set", raw_status, 11'h130);
    reg_write(2'd3, 16'h0110);
    check("R5", "partial clear", raw_status, 11'h020);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd3; wr_data = 16'h0020; hw_set = 11'h020;
    @(negedge clk);
    wr_en = 1'b0; hw_set = '0;
    check("R5", "set beats clear", raw_status, 11'h020);
    reg_write(2'd3, 16'h07FF);
  endtask

  task automatic t_tx;
    reg_write(2'd0, 16'h0041);
    check("R6", "tx raw", raw_status, 11'h020);
    check("R10", "no loop item", rxq_valid, 0);
    @(negedge clk);
    check("R6", "irq_tx", irq_tx, 1);
    reg_write(2'd3, 16'h07FF);
  endtask

  task automatic t_loop_map;
    set_pulse(11'h006);
    reg_write(2'd1, 16'h0013);
    check("R7", "flags dtr+out2", modem_flags, 4'b1001);
    check("R8", "modem raw rebuilt", raw_status[3:0], 4'b1001);
    @(negedge clk);
    check("R3", "irq_mdm", irq_mdm, 1);
    reg_write(2'd1, 16'h0005);
    check("R7", "flags rts", modem_flags, 4'b0010);
    check("R8", "modem raw rts", raw_status[3:0], 4'b0010);
    reg_write(2'd1, 16'h001E);
    check("R7", "flags hold loop off", modem_flags, 4'b0010);
    check("R8", "raw hold loop off", raw_status[3:0], 4'b0010);
    reg_write(2'd3, 16'h07FF);
  endtask

  task automatic t_loop_stream;
    rxq_ready = 1'b0;
    reg_write(2'd1, 16'h0001);
    reg_write(2'd0, 16'h005A);
    check("R9", "loop valid", rxq_valid, 1);
    check("R9", "loop byte", rxq_data, 9'h05A);
    check("R6", "tx raw in loop", raw_status[5], 1);
    reg_write(2'd0, 16'h0077);
    check("R11", "slot kept", rxq_data, 9'h05A);
    @(negedge clk);
    ext_valid = 1'b1; ext_data = 9'h1FF;
    #1;
    check("R10", "ext sunk", ext_ready, 1);
    check("R10", "ext not forwarded", rxq_data, 9'h05A);
    rxq_ready = 1'b1;
    @(negedge clk);
    check("R11", "drained, second dropped", rxq_valid, 0);
    ext_valid = 1'b0;
    reg_write(2'd1, 16'h0021);
    check("R9", "break valid", rxq_valid, 1);
    check("R9", "break item", rxq_data, 9'h100);
    @(negedge clk);
    check("R11", "break drained", rxq_valid, 0);
    reg_write(2'd3, 16'h07FF);
  endtask

  task automatic t_passthru;
    reg_write(2'd1, 16'h0000);
    @(negedge clk);
    ext_valid = 1'b1; ext_data = 9'h0C3; rxq_ready = 1'b1;
    #1;
    check("R10", "pass valid", rxq_valid, 1);
    check("R10", "pass data", rxq_data, 9'h0C3);
    check("R10", "pass ready", ext_ready, 1);
    rxq_ready = 1'b0;
    #1;
    check("R10", "pass backpressure", ext_ready, 0);
    ext_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_route();
    t_combined();
    t_clear();
    t_tx();
    t_loop_map();
    t_loop_stream();
    t_passthru();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule